// File: doc/BRIEF.md
# Three-Wire Windowed Register Write Slave

This block receives register writes from a host over three wires: a serial clock, an active-low load strobe and a serial data line. Each frame opens with the load strobe falling. All fields are shifted in MSB first, and one bit is taken on each rising serial clock edge. The first eight bits are an address. An address below a parameterised boundary gives a short control frame, which carries one 24-bit word. An address at or above the boundary names a register bank. A bank frame carries a 12-bit first index, then a 12-bit last index, then a stream of 32-bit words.

A bank frame with a non-zero index pair writes the words to ascending indices, from the first index up to and including the last. When both indices are zero the frame becomes a whole-bank burst. The burst writes every register of the bank, starting at index 0. During a burst the load strobe is not looked at until the final word is in.

Each accepted word gives one single-cycle write strobe, together with the bank, the index, the data and a flag that tells control writes from bank writes. For a set number of system clock cycles after reset, every frame is thrown away.

The serial pins are brought into the system clock domain through synchronisers and are sampled by edge detection. The serial clock must therefore stay well below the system clock rate.

Top module: `w3_win_wr`

## Requirements
- R1: A frame whose address byte is below BANK_BASE (default 8'h14) is a control frame: 8 address bits, then 24 data bits. It gives exactly one write with wr_ctrl_o=1, wr_bank_o equal to the address, wr_index_o=0 and wr_data_o equal to the 24 bits zero-extended to 32 bits.
- R2: A control frame ended by the load strobe rising before its 32nd bit gives no write.
- R3: An address at or above BANK_BASE selects the bank format: 8-bit bank, 12-bit first index, 12-bit last index, then 32-bit words. Every write from such a frame has wr_ctrl_o=0 and wr_bank_o equal to the bank.
- R4: When the index pair is not both zero, the words are written to consecutive ascending indices from the first index to the last index inclusive. Writing stops after the last index.
- R5: A bank frame whose first index is greater than its last index (and not both zero) writes nothing.
- R6: When both indices are zero, the frame writes indices 0 to BANK_REGS-1 in order. A rise of the load strobe before the final word is ignored.
- R7: In window mode, a load strobe rise before the last index is reached ends the frame. Words already received stay written and nothing more is written.
- R8: Bits clocked in after a frame has completed are ignored until the load strobe rises and falls again.
- R9: No write is issued for a frame that starts before POR_CYCLES system clock cycles have passed since reset release.
- R10: After reset wr_valid_o is low, and each write strobe lasts exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock; data taken on its rising edge |
| load_ni | input | 1 | Active-low frame load strobe |
| sdata_i | input | 1 | Serial data, MSB first |
| wr_valid_o | output | 1 | Single-cycle write strobe |
| wr_ctrl_o | output | 1 | 1 for a control write, 0 for a bank write |
| wr_bank_o | output | 8 | Control address or bank address |
| wr_index_o | output | 12 | Register index within the bank |
| wr_data_o | output | 32 | Write data |

## Verification
The bench builds the block with POR_CYCLES set to 400. With that value a complete control frame can be sent inside the blocking window and its loss observed, and the bench can then move straight on to normal traffic. BANK_REGS stays at its default of 16, so a full burst can be run with an early load rise placed in its middle. BANK_BASE stays at 8'h14, so random addresses land on both sides of the format boundary. Random windows cover index values across the whole 12-bit range, and random aborted windows cover partial writes.

// File: rtl/w3_pkg.sv
package w3_pkg;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 12;
  localparam int WORD_W = 32;
  localparam int CTRL_W = 24;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DATA, ST_HOLD} w3_state_e;
endpackage

// File: rtl/w3_sync.sv
module w3_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q[0] <= RST_VAL;
    else         st_q[0] <= d_i;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) st_q[s] <= RST_VAL;
      else         st_q[s] <= st_q[s-1];
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/w3_por_gate.sv
module w3_por_gate #(
  parameter int CYCLES = 12000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 2);
  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == CW'(CYCLES));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
endmodule

// File: rtl/w3_frame.sv
module w3_frame
  import w3_pkg::*;
#(
  parameter logic [7:0] BANK_BASE = 8'h14,
  parameter int         BANK_REGS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bit_stb_i,
  input  logic              bit_i,
  input  logic              load_fall_i,
  input  logic              load_high_i,
  output logic              wr_valid_o,
  output logic              wr_ctrl_o,
  output logic [ADDR_W-1:0] wr_bank_o,
  output logic [IDX_W-1:0]  wr_index_o,
  output logic [WORD_W-1:0] wr_data_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BANK_REGS - 1);

  w3_state_e         state_q;
  logic [4:0]        cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ctrl_q, burst_q;
  logic [IDX_W-1:0]  idx_q, first_q, last_q;
  logic [WORD_W-1:0] nxt;

  assign nxt = {sh_q[WORD_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      addr_q     <= '0;
      ctrl_q     <= 1'b0;
      burst_q    <= 1'b0;
      idx_q      <= '0;
      first_q    <= '0;
      last_q     <= '0;
      wr_valid_o <= 1'b0;
      wr_ctrl_o  <= 1'b0;
      wr_bank_o  <= '0;
      wr_index_o <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (load_fall_i) begin
            state_q <= ST_HDR;
            cnt_q   <= '0;
          end
          ST_HDR: begin
            if (load_high_i) state_q <= ST_IDLE;
            else if (bit_stb_i) begin
              sh_q  <= nxt;
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == 5'd7) begin
                addr_q <= nxt[ADDR_W-1:0];
                ctrl_q <= (nxt[ADDR_W-1:0] < BANK_BASE);
              end
              if (cnt_q == 5'd31) begin
                if (ctrl_q) begin
                  wr_valid_o <= 1'b1;
                  wr_ctrl_o  <= 1'b1;
                  wr_bank_o  <= addr_q;
                  wr_index_o <= '0;
                  wr_data_o  <= {{(WORD_W-CTRL_W){1'b0}}, nxt[CTRL_W-1:0]};
                  state_q    <= ST_HOLD;
                end else begin
                  first_q <= nxt[2*IDX_W-1:IDX_W];
                  last_q  <= nxt[IDX_W-1:0];
                  idx_q   <= nxt[2*IDX_W-1:IDX_W];
                  burst_q <= (nxt[2*IDX_W-1:0] == '0);
                  if (nxt[2*IDX_W-1:0] != '0 && nxt[2*IDX_W-1:IDX_W] > nxt[IDX_W-1:0])
                    state_q <= ST_HOLD;
                  else
                    state_q <= ST_DATA;
                end
              end
            end
          end
          ST_DATA: begin
            if (load_high_i && !burst_q) state_q <= ST_IDLE;
            else if (bit_stb_i) begin
              sh_q  <= nxt;
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == 5'd31) begin
                wr_valid_o <= 1'b1;
                wr_ctrl_o  <= 1'b0;
                wr_bank_o  <= addr_q;
                wr_index_o <= idx_q;
                wr_data_o  <= nxt;
                if (burst_q ? (idx_q == LAST_IDX) : (idx_q == last_q))
                  state_q <= ST_HOLD;
                else
                  idx_q <= idx_q + 1'b1;
              end
            end
          end
          ST_HOLD: if (load_high_i) state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R1: control writes carry a control address, index 0, upper data byte clear
  a_r1_ctrl_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && wr_ctrl_o |-> wr_data_o[31:24] == '0 && wr_index_o == '0 && wr_bank_o < BANK_BASE);
  // R4: window writes stay inside the index window
  a_r4_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ctrl_o && !burst_q |-> wr_index_o >= first_q && wr_index_o <= last_q);
  // R6: burst writes stay inside the bank
  a_r6_burst_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ctrl_o && burst_q |-> wr_index_o <= LAST_IDX);
  // R3: bank writes name a bank address
  a_r3_bank_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ctrl_o |-> wr_bank_o >= BANK_BASE);
endmodule

// File: rtl/w3_win_wr.sv
module w3_win_wr
  import w3_pkg::*;
#(
  parameter logic [7:0] BANK_BASE   = 8'h14,
  parameter int         BANK_REGS   = 16,
  parameter int         POR_CYCLES  = 12000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sck_i,
  input  logic        load_ni,
  input  logic        sdata_i,
  output logic        wr_valid_o,
  output logic        wr_ctrl_o,
  output logic [7:0]  wr_bank_o,
  output logic [11:0] wr_index_o,
  output logic [31:0] wr_data_o
);
  logic [2:0] pins_s;
  logic       sck_q, load_q, por_done;
  logic       sck_rise, load_fall;

  w3_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, load_ni, sdata_i}),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      load_q <= 1'b1;
    end else begin
      sck_q  <= pins_s[2];
      load_q <= pins_s[1];
    end

  assign sck_rise  = pins_s[2] & ~sck_q;
  assign load_fall = ~pins_s[1] & load_q;

  w3_por_gate #(.CYCLES(POR_CYCLES)) u_por (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_o(por_done)
  );

  w3_frame #(.BANK_BASE(BANK_BASE), .BANK_REGS(BANK_REGS)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (por_done),
    .bit_stb_i  (sck_rise),
    .bit_i      (pins_s[0]),
    .load_fall_i(load_fall),
    .load_high_i(pins_s[1]),
    .wr_valid_o (wr_valid_o),
    .wr_ctrl_o  (wr_ctrl_o),
    .wr_bank_o  (wr_bank_o),
    .wr_index_o (wr_index_o),
    .wr_data_o  (wr_data_o)
  );

  // R9: nothing is written while the power-on window is open
  a_r9_por_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_done |-> !wr_valid_o);
  // R10: write strobe is a single-cycle pulse
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);
endmodule

// File: tb/sim_w3_win_wr.sv
module sim_w3_win_wr;
  localparam int CLK_NS = 10;
  localparam int HALF   = 4;
  localparam int POR    = 400;
  localparam int NREG   = 16;

  typedef struct packed {
    logic        ctrl;
    logic [7:0]  bank;
    logic [11:0] idx;
    logic [31:0] data;
  } rec_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, load_n = 1'b1, sdata = 1'b0;
  logic wr_valid, wr_ctrl;
  logic [7:0] wr_bank;
  logic [11:0] wr_index;
  logic [31:0] wr_data;
  int n_chk = 0, n_bad = 0, dbl = 0;
  logic last_v = 1'b0;
  rec_t exp_q[$], got_q[$];

  always #(CLK_NS/2) clk = ~clk;

  w3_win_wr #(.BANK_REGS(NREG), .POR_CYCLES(POR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .load_ni(load_n), .sdata_i(sdata),
    .wr_valid_o(wr_valid), .wr_ctrl_o(wr_ctrl), .wr_bank_o(wr_bank),
    .wr_index_o(wr_index), .wr_data_o(wr_data));

  always @(negedge clk) begin
    if (wr_valid) got_q.push_back({wr_ctrl, wr_bank, wr_index, wr_data});
    if (wr_valid && last_v) dbl++;
    last_v <= wr_valid;
  end

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  task automatic clks(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = v[i];
      clks(HALF); sck = 1'b1;
      clks(HALF); sck = 1'b0;
    end
  endtask

  task automatic open_f();
    load_n = 1'b0; clks(2*HALF);
  endtask

  task automatic close_f();
    clks(2*HALF); load_n = 1'b1; clks(4*HALF);
  endtask

  function automatic rec_t mk(logic c, logic [7:0] b, logic [11:0] i, logic [31:0] d);
    return {c, b, i, d};
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (got_q.size() != exp_q.size()) begin
      n_bad++;
      $display("FAIL %s: write count actual=%0d expected=%0d", tag, got_q.size(), exp_q.size());
    end else
      foreach (exp_q[k]) begin
        n_chk++;
        if (got_q[k] !== exp_q[k]) begin
          n_bad++;
          $display("FAIL %s: write %0d actual=%h expected=%h", tag, k, got_q[k], exp_q[k]);
        end
      end
    got_q.delete(); exp_q.delete();
  endtask

  task automatic ctrl_f(logic [7:0] a, logic [23:0] d, int extra);
    open_f(); send({24'h0, a}, 8); send({8'h0, d}, 24);
    if (extra > 0) send(32'hFFFF_FFFF, extra);
    close_f();
  endtask

  task automatic win_f(logic [7:0] b, logic [11:0] s, logic [11:0] e, int words, logic [31:0] seed_d);
    open_f(); send({24'h0, b}, 8); send({20'h0, s}, 12); send({20'h0, e}, 12);
    for (int w = 0; w < words; w++) send(seed_d + 32'(w) * 32'h0101_0101, 32);
    close_f();
  endtask

  initial begin
    void'($urandom(32'd11));
    clks(3);
    n_chk++;
    if (wr_valid !== 1'b0) begin
      n_bad++; $display("FAIL R10 reset: wr_valid actual=%b expected=0", wr_valid);
    end
    rst_n = 1'b1;
    clks(2);
    // R9: full control frame inside the blocking window
    ctrl_f(8'h03, 24'hABCDEF, 0);
    check("R9 por block");
    clks(POR);
    // R1
    ctrl_f(8'h05, 24'h123456, 0);
    exp_q.push_back(mk(1'b1, 8'h05, 12'h0, 32'h0012_3456));
    check("R1 control");
    ctrl_f(8'h13, 24'hFFFFFF, 0);
    exp_q.push_back(mk(1'b1, 8'h13, 12'h0, 32'h00FF_FFFF));
    check("R1 boundary address");
    // R2
    open_f(); send(32'h07, 8); send(32'h55, 12); close_f();
    check("R2 short control");
    // R8
    ctrl_f(8'h01, 24'h00A5A5, 16);
    exp_q.push_back(mk(1'b1, 8'h01, 12'h0, 32'h0000_A5A5));
    check("R8 trailing bits");
    // R3 R4: window 2..4
    win_f(8'h14, 12'd2, 12'd4, 3, 32'h1000_0000);
    for (int k = 0; k < 3; k++)
      exp_q.push_back(mk(1'b0, 8'h14, 12'(2 + k), 32'h1000_0000 + 32'(k) * 32'h0101_0101));
    check("R4 window 2-to-4");
    // R4 R8: single register, extra word ignored
    win_f(8'h15, 12'd6, 12'd6, 2, 32'hCAFE_0000);
    exp_q.push_back(mk(1'b0, 8'h15, 12'd6, 32'hCAFE_0000));
    check("R4 single register");
    // R5
    win_f(8'h16, 12'd9, 12'd3, 2, 32'h0);
    check("R5 reversed window");
    // R6: burst, load rises mid-way and is ignored
    open_f(); send(32'h17, 8); send(32'h0, 24);
    for (int w = 0; w < NREG; w++) begin
      if (w == 5) begin load_n = 1'b1; clks(6*HALF); end
      if (w == 7) begin load_n = 1'b0; clks(2*HALF); end
      send(32'hB000_0000 + 32'(w), 32);
      exp_q.push_back(mk(1'b0, 8'h17, 12'(w), 32'hB000_0000 + 32'(w)));
    end
    send(32'hDEAD_BEEF, 32);
    close_f();
    check("R6 burst");
    // R7: abort after two words
    win_f(8'h20, 12'd10, 12'd20, 2, 32'h7700_0000);
    for (int k = 0; k < 2; k++)
      exp_q.push_back(mk(1'b0, 8'h20, 12'(10 + k), 32'h7700_0000 + 32'(k) * 32'h0101_0101));
    check("R7 abort");
    // random mix
    for (int it = 0; it < 24; it++) begin
      int kind = int'($urandom % 3);
      logic [31:0] d = $urandom;
      if (kind == 0) begin
        logic [7:0] a = 8'($urandom % 20);
        ctrl_f(a, d[23:0], 0);
        exp_q.push_back(mk(1'b1, a, 12'h0, {8'h0, d[23:0]}));
        check("R1 random control");
      end else begin
        logic [7:0] b = 8'(8'h14 + $urandom % 8'hEB);
        logic [11:0] s = 12'(1 + $urandom % 4090);
        int len = 1 + int'($urandom % 4);
        int sent = (kind == 2) ? len - 1 : len;
        win_f(b, s, s + 12'(len - 1), sent, d);
        for (int k = 0; k < sent; k++)
          exp_q.push_back(mk(1'b0, b, s + 12'(k), d + 32'(k) * 32'h0101_0101));
        check(kind == 2 ? "R7 random abort" : "R4 random window");
      end
    end
    n_chk++;
    if (dbl != 0) begin
      n_bad++; $display("FAIL R10 pulse width: double strobes actual=%0d expected=0", dbl);
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule